// File: doc/BRIEF.md
# Multiplexed Multiphase Counter Time-to-Digital Converter

This block turns the period of a resistance-controlled sensor oscillator into a digital word. The oscillator arrives as a digital edge stream. Its frequency depends on whichever sensor is currently switched onto it. The block counts a programmable number N of oscillator rising edges, and the span they cover forms a measurement window. It measures that window on the reference clock in two parts. The coarse part counts whole reference cycles. The fine part samples eight reference phases at each window edge, which adds three bits of resolution below one reference period.

A single converter serves nine sensors in turn. After a start request, the block selects sensor 0 and runs through to sensor 8. Each sensor gets one settling window and one measured window. Each finished measurement is reported with its sensor index and a one-cycle valid strobe. A larger N gives finer resolution at the cost of a longer conversion.

Top module: `ms_tdc`

## Requirements
- R1: After reset, `busy`, `res_valid` and `res_ovf` are 0, and `sel_chan` is 0.
- R2: A `start` pulse while idle begins a scan. `sel_chan` steps from 0 to 8 and exactly one result is produced per sensor. `busy` falls with the result for sensor 8.
- R3: Each result carries in `res_chan` the index of the sensor that was selected while it was measured.
- R4: `div_ratio` sets N, where the value 0 stands for 256. The coarse count is the number of reference cycles between the N-th and the 2N-th detected oscillator rising edge after a sensor switch. For an oscillator period of P reference cycles, the coarse count is N·P.
- R5: The first N oscillator edges after each sensor switch form a settling period that is discarded. They do not contribute to the result.
- R6: The fine code is the number of ones in `phase_in[7:1]` (thermometer code, 0 to 7), sampled in the cycle an edge is detected. The result is coarse·8 + fine_at_close − fine_at_open.
- R7: `res_valid` is high for exactly one cycle per result.
- R8: If the coarse count exceeds 2^CNT_W − 1, `res_ovf` is 1 with that result and `res_value` is all ones.
- R9: A `start` pulse while a scan is running has no effect. The scan goes on with the same sensor order and result count.
- R10: Oscillator edges while idle produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, phase 0 |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a nine-sensor scan |
| osc_in | input | 1 | Sensor oscillator output, asynchronous |
| phase_in | input | 8 | Snapshot of the eight reference phases |
| div_ratio | input | 8 | Divided periods per window, 0 means 256 |
| busy | output | 1 | A scan is in progress |
| sel_chan | output | 4 | Sensor currently switched onto the oscillator |
| res_valid | output | 1 | Result strobe |
| res_chan | output | 4 | Sensor index of the result |
| res_value | output | CNT_W+3 | Combined coarse and fine result |
| res_ovf | output | 1 | Coarse counter saturated |

## Verification
The properties assume that `phase_in` is a thermometer pattern held stable around each oscillator edge. They also assume that the oscillator period is at least four reference cycles, so that a sensor switch completes before the next edge is detected. The stimulus drives every oscillator edge with a period of four to twelve cycles, and it updates the phase pattern only together with a rising edge. Sweeps over several values of N, including 1 and 256, cover both exact and saturated windows.

// File: rtl/ms_tdc.sv
module ms_tdc #(
  parameter int CNT_W = 16,
  parameter int NCH   = 9,
  parameter int PH    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          osc_in,
  input  logic [PH-1:0]                 phase_in,
  input  logic [7:0]                    div_ratio,
  output logic                          busy,
  output logic [$clog2(NCH)-1:0]        sel_chan,
  output logic                          res_valid,
  output logic [$clog2(NCH)-1:0]        res_chan,
  output logic [CNT_W+$clog2(PH)-1:0]   res_value,
  output logic                          res_ovf
);
  localparam int FW = $clog2(PH);
  localparam int RW = CNT_W + FW;
  localparam int CW = $clog2(NCH);
  localparam logic [CNT_W-1:0] CMAX = '1;

  typedef enum logic [1:0] {IDLE, SETTLE, MEAS} st_t;
  st_t st;

  logic [2:0]       osc_s;
  logic [8:0]       ecnt, n_eff;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             ovf, ovf_n, rise, hit;
  logic [FW-1:0]    fine, fstart;

  assign rise    = osc_s[1] & ~osc_s[2];
  assign n_eff   = (div_ratio == 8'd0) ? 9'd256 : {1'b0, div_ratio};
  assign hit     = rise && (ecnt + 9'd1 == n_eff);
  assign cnt_nxt = (cnt == CMAX) ? CMAX : cnt + 1'b1;
  assign ovf_n   = ovf | (cnt == CMAX);
  assign busy    = (st != IDLE);

  always_comb begin
    fine = '0;
    for (int i = 1; i < PH; i++) fine = fine + FW'(phase_in[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) osc_s <= '0;
    else        osc_s <= {osc_s[1:0], osc_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      ecnt      <= '0;
      cnt       <= '0;
      ovf       <= 1'b0;
      fstart    <= '0;
      sel_chan  <= '0;
      res_valid <= 1'b0;
      res_chan  <= '0;
      res_value <= '0;
      res_ovf   <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (st)
        IDLE: if (start) begin
          st       <= SETTLE;
          sel_chan <= '0;
          ecnt     <= '0;
        end
        SETTLE: if (rise) begin
          if (hit) begin
            st     <= MEAS;
            ecnt   <= '0;
            cnt    <= '0;
            ovf    <= 1'b0;
            fstart <= fine;
          end else ecnt <= ecnt + 9'd1;
        end
        MEAS: begin
          cnt <= cnt_nxt;
          ovf <= ovf_n;
          if (rise) begin
            if (hit) begin
              res_valid <= 1'b1;
              res_chan  <= sel_chan;
              res_ovf   <= ovf_n;
              res_value <= ovf_n ? {RW{1'b1}}
                                 : {cnt_nxt, {FW{1'b0}}} + RW'(fine) - RW'(fstart);
              ecnt      <= '0;
              if (sel_chan == CW'(NCH-1)) st <= IDLE;
              else begin
                st       <= SETTLE;
                sel_chan <= sel_chan + 1'b1;
              end
            end else ecnt <= ecnt + 9'd1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ms_tdc_sva.sv
module ms_tdc_sva #(
  parameter int CNT_W = 16,
  parameter int NCH   = 9,
  parameter int PH    = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        busy,
  input logic [$clog2(NCH)-1:0]      sel_chan,
  input logic                        res_valid,
  input logic [$clog2(NCH)-1:0]      res_chan,
  input logic [CNT_W+$clog2(PH)-1:0] res_value,
  input logic                        res_ovf
);
  localparam int CW = $clog2(NCH);

  a_r2_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
    sel_chan <= CW'(NCH-1));

  a_r2_chan_step: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_chan != CW'(NCH-1)) |-> (sel_chan == res_chan + 1'b1) && busy);

  a_r3_tag_matches_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> res_chan == $past(sel_chan));

  a_r7_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  a_r8_ovf_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ovf) |-> (&res_value));

  a_r10_result_needs_scan: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(busy));
endmodule

bind ms_tdc ms_tdc_sva #(.CNT_W(CNT_W), .NCH(NCH), .PH(PH)) sva_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sel_chan(sel_chan),
  .res_valid(res_valid), .res_chan(res_chan), .res_value(res_value),
  .res_ovf(res_ovf)
);

// File: tb/ms_tdc_tb.sv
`timescale 1ns/1ps
module ms_tdc_tb_top;
  localparam int CW_T = 11;
  localparam int RW = CW_T + 3;
  localparam int CMAX = (1 << CW_T) - 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, osc_in = 1'b0;
  logic [7:0] phase_in = 8'h01, div_ratio = 8'd1;
  logic busy, res_valid, res_ovf;
  logic [3:0] sel_chan, res_chan;
  logic [RW-1:0] res_value;

  int total = 0, bad = 0;
  int exp_val [9], exp_ovf [9];
  int exp_n = 0, got = 0;
  logic prev_valid = 1'b0;

  always #2 clk = ~clk;

  ms_tdc #(.CNT_W(CW_T)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .osc_in(osc_in),
    .phase_in(phase_in), .div_ratio(div_ratio), .busy(busy),
    .sel_chan(sel_chan), .res_valid(res_valid), .res_chan(res_chan),
    .res_value(res_value), .res_ovf(res_ovf)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fv(input int e, input int c);
    return (e * 3 + c) % 8;
  endfunction

  function automatic logic [7:0] therm(input int v);
    return 8'(((1 << v) - 1) << 1) | 8'h01;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      check(!(prev_valid && res_valid), "R7 valid width", 2, 1);
      if (res_valid) begin
        if (got >= exp_n) check(1'b0, "R10 unexpected result", got + 1, exp_n);
        else begin
          check(res_chan == 4'(got), "R3 channel tag", res_chan, got);
          check(int'(res_value) == exp_val[got], "R4 R6 value", res_value, exp_val[got]);
          check(res_ovf == exp_ovf[got][0], "R8 overflow flag", res_ovf, exp_ovf[got]);
        end
        got++;
      end
      prev_valid = res_valid;
    end
  end

  task automatic sweep(input int nr, input bit mid_start);
    int n;
    n = (nr == 0) ? 256 : nr;
    div_ratio = 8'(nr);
    got = 0;
    exp_n = 9;
    for (int c = 0; c < 9; c++) begin
      int p, cc;
      p = 4 + c;
      cc = n * p;
      if (cc > CMAX) begin
        exp_ovf[c] = 1;
        exp_val[c] = (1 << RW) - 1;
      end else begin
        exp_ovf[c] = 0;
        exp_val[c] = cc * 8 + fv(2 * n, c) - fv(n, c);
      end
    end
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    for (int c = 0; c < 9; c++) begin
      for (int e = 1; e <= 2 * n; e++) begin
        phase_in = therm(fv(e, c));
        osc_in = 1'b1;
        if (mid_start && c == 4 && e == 1) start = 1'b1;  // R9
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        osc_in = 1'b0;
        for (int w = 0; w < 2 + c; w++) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
    check(got == 9, "R2 R9 result count", got, 9);
    check(busy == 1'b0, "R2 busy after sensor 8", busy, 0);
  endtask

  initial begin
    #(200000 * 4);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy reset", busy, 0);
    check(res_valid == 1'b0, "R1 valid reset", res_valid, 0);
    check(res_ovf == 1'b0, "R1 ovf reset", res_ovf, 0);
    check(sel_chan == 4'd0, "R1 sel reset", sel_chan, 0);
    rst_n = 1'b1;
    // R10: edges while idle
    for (int e = 0; e < 6; e++) begin
      osc_in = 1'b1;
      repeat (2) @(negedge clk);
      osc_in = 1'b0;
      repeat (3) @(negedge clk);
    end
    check(got == 0, "R10 idle edges", got, 0);
    // R5 is covered by every sweep: settling edges carry different fine codes
    sweep(1, 1'b0);
    sweep(2, 1'b1);
    sweep(3, 1'b0);
    sweep(5, 1'b0);
    sweep(8, 1'b1);
    sweep(0, 1'b0);  // N = 256, R8 saturation for slower sensors
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule